// File: doc/BRIEF.md
# ROM Verification Stream Sequencer

This block is a test-mode engine that proves the contents of an on-chip read-only program array against a byte stream supplied by an external tester. Three strap inputs, sampled while reset is held, decide whether the engine runs. Once reset is released in that mode, the block emits a periodic strobe. On each strobe it takes one expected byte from the 8-bit data port and compares it with the array word at an internal pointer. The pointer starts at zero and advances by one per strobe.

No address ever leaves the block. The tester tracks its position by counting strobes. After every group of sixteen consecutive addresses, a single verdict pin reports whether any byte in that group disagreed. The pin holds that result until the next group closes. The array contents come from a fixed arithmetic formula, so no file is needed to load them.

Top module: `rom_verify_seq`

## Requirements
- R1: The engine runs only if, while `rst_i` is high, `strap_strobe_i` is 0, `strap_fetch_i` is 1 and `strap_ext_i` is 1. With any other strap combination, after release `strobe_o` stays 0 and `verdict_o` stays 1 whatever `data_i` does.
- R2: While `rst_i` is high, `strobe_o` is 0 and `verdict_o` is 1.
- R3: Call the first rising clock edge with `rst_i` low edge 0. The first `strobe_o` pulse rises at edge 6, and `strobe_o` is 0 from edge 0 up to that point.
- R4: After the first pulse, `strobe_o` is high for exactly one cycle in every 3, rising at edges 6+3n.
- R5: `data_i` is sampled at the rising edge that ends each high cycle of `strobe_o`. Pulse n (n from 0) is compared with array address n mod DEPTH. The byte for address 0 must be present from reset release.
- R6: The array word at address a is the low 8 bits of (a*29+7) XOR (a>>4).
- R7: After address DEPTH-1 the pointer wraps to 0 and the sequence continues without a break.
- R8: At the edge that samples the byte for an address whose low four bits are all ones, `verdict_o` becomes 0 if any byte of that group of 16 mismatched, including the byte sampled at that same edge. Otherwise it becomes 1.
- R9: `verdict_o` changes only at group-closing edges. The mismatch memory is cleared at each group close, so every group is judged on its own bytes.
- R10: Raising `rst_i` again at any point stops the stream. The next release restarts from address 0 with a clean group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; the straps are sampled while it is high |
| strap_strobe_i | input | 1 | Strap level; must be 0 to select the mode |
| strap_fetch_i | input | 1 | Strap level; must be 1 to select the mode |
| strap_ext_i | input | 1 | Strap level; must be 1 to select the mode |
| data_i | input | 8 | Expected byte from the tester |
| strobe_o | output | 1 | Periodic strobe; one byte is taken per pulse |
| verdict_o | output | 1 | Group result: 1 means all bytes matched, 0 means a mismatch was seen |

## Verification
Two things can happen at the same edge: the sixteenth byte of a group is compared, and the group result is moved to the pin while the mismatch memory is cleared. The bench forces a bad byte exactly at that edge, at the first byte of the following group, and at the last array address, where the wrap also falls on a group close. It also injects random bad bytes. A cycle-by-cycle bench model predicts `strobe_o` and `verdict_o` from the strobe count alone. The bench compares both outputs against that model in every cycle.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
    // Word stored at array address a; callers keep the low data bits.
    function automatic logic [31:0] rom_word(input int unsigned a);
        logic [31:0] v;
        v = (a * 32'd29) + 32'd7;
        return v ^ (a >> 4);
    endfunction
endpackage

// File: rtl/rvs_timer.sv
module rvs_timer #(
    parameter int FIRST_DLY = 6,
    parameter int PERIOD    = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic strap_strobe_i,
    input  logic strap_fetch_i,
    input  logic strap_ext_i,
    output logic strobe_o
);
    localparam int MAXC = (FIRST_DLY > PERIOD) ? FIRST_DLY : PERIOD;
    localparam int CW   = $clog2(MAXC) + 1;

    typedef struct packed {
        logic          mode_sel;
        logic          active;
        logic          strobe;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (rst_i) begin
            tmr_d.mode_sel = !strap_strobe_i && strap_fetch_i && strap_ext_i;
            tmr_d.active   = 1'b0;
            tmr_d.strobe   = 1'b0;
            tmr_d.cnt      = '0;
        end else if (!tmr_q.active) begin
            if (tmr_q.mode_sel) begin
                tmr_d.active = 1'b1;
                tmr_d.cnt    = CW'(FIRST_DLY - 1);
            end
        end else if (tmr_q.cnt == '0) begin
            tmr_d.strobe = 1'b1;
            tmr_d.cnt    = CW'(PERIOD - 1);
        end else begin
            tmr_d.strobe = 1'b0;
            tmr_d.cnt    = tmr_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        tmr_q <= tmr_d;
    end

    assign strobe_o = tmr_q.strobe;

    // R4: every strobe lasts a single cycle
    assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        tmr_q.strobe |=> !tmr_q.strobe);
    // R1: no strobe unless the mode was selected
    assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        !tmr_q.mode_sel |-> !tmr_q.strobe);
    // R3: activation at release is never accompanied by a strobe
    assert_first_quiet_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(tmr_q.active) |-> !tmr_q.strobe);
endmodule

// File: rtl/rvs_rom.sv
module rvs_rom #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr_i,
    output logic [DW-1:0] data_o
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign mem[i] = DW'(rvs_pkg::rom_word(i));
    end

    assign data_o = mem[addr_i];
endmodule

// File: rtl/rvs_check.sv
module rvs_check #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    parameter int GROUP = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int GW   = $clog2(GROUP)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          take_i,
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] rom_i,
    output logic [AW-1:0] addr_o,
    output logic          verdict_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          err;
        logic          verdict;
    } chk_t;

    chk_t chk_d, chk_q;
    logic mism;
    logic grp_end;

    assign mism    = (data_i != rom_i);
    assign grp_end = &chk_q.addr[GW-1:0];

    always_comb begin
        chk_d = chk_q;
        if (rst_i) begin
            chk_d.addr    = '0;
            chk_d.err     = 1'b0;
            chk_d.verdict = 1'b1;
        end else if (take_i) begin
            chk_d.addr = (chk_q.addr == LAST) ? '0 : chk_q.addr + AW'(1);
            if (grp_end) begin
                chk_d.verdict = !(chk_q.err || mism);
                chk_d.err     = 1'b0;
            end else begin
                chk_d.err = chk_q.err || mism;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        chk_q <= chk_d;
    end

    assign addr_o    = chk_q.addr;
    assign verdict_o = chk_q.verdict;

    initial assert (DEPTH % GROUP == 0 && DEPTH >= GROUP);

    // R9: verdict only moves on a strobe
    assert_verdict_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !take_i |=> $stable(chk_q.verdict));
    // R5: pointer holds between strobes
    assert_addr_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !take_i |=> $stable(chk_q.addr));
    // R7: wrap from the last address to zero
    assert_addr_wrap_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (take_i && chk_q.addr == LAST) |=> chk_q.addr == '0);
    // R8: a bad closing byte forces a failing verdict
    assert_last_byte_fail_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (take_i && grp_end && (data_i != rom_i)) |=> !chk_q.verdict);
endmodule

// File: rtl/rom_verify_seq.sv
module rom_verify_seq #(
    parameter int DEPTH     = 256,
    parameter int DW        = 8,
    parameter int GROUP     = 16,
    parameter int FIRST_DLY = 6,
    parameter int PERIOD    = 3
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          strap_strobe_i,
    input  logic          strap_fetch_i,
    input  logic          strap_ext_i,
    input  logic [DW-1:0] data_i,
    output logic          strobe_o,
    output logic          verdict_o
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] addr;
    logic [DW-1:0] rom_word;
    logic          strobe;

    rvs_timer #(.FIRST_DLY(FIRST_DLY), .PERIOD(PERIOD)) u_timer (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .strap_strobe_i (strap_strobe_i),
        .strap_fetch_i  (strap_fetch_i),
        .strap_ext_i    (strap_ext_i),
        .strobe_o       (strobe)
    );

    rvs_rom #(.DEPTH(DEPTH), .DW(DW)) u_rom (
        .addr_i (addr),
        .data_o (rom_word)
    );

    rvs_check #(.DEPTH(DEPTH), .DW(DW), .GROUP(GROUP)) u_check (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .take_i    (strobe),
        .data_i    (data_i),
        .rom_i     (rom_word),
        .addr_o    (addr),
        .verdict_o (verdict_o)
    );

    assign strobe_o = strobe;

    // R10: a fresh run starts at address zero
    assert_restart_zero_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> addr == '0);
    // R2: held reset keeps the outputs at rest
    assert_reset_rest_R2: assert property (@(posedge clk_i)
        $past(rst_i) && rst_i |-> (!strobe_o && verdict_o));
endmodule

// File: tb/tb_rom_verify_seq.sv
module tb_rom_verify_seq;
    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       s_strobe = 1'b0, s_fetch = 1'b1, s_ext = 1'b1;
    logic [7:0] data = 8'h00;
    logic       strobe_o, verdict_o;

    int  n_chk = 0, n_err = 0;
    bit  done = 1'b0;
    bit  grp_err;
    bit  exp_v;
    int  seed;

    rom_verify_seq dut (
        .clk_i(clk), .rst_i(rst),
        .strap_strobe_i(s_strobe), .strap_fetch_i(s_fetch), .strap_ext_i(s_ext),
        .data_i(data), .strobe_o(strobe_o), .verdict_o(verdict_o)
    );

    always #4 clk = ~clk;

    function automatic int exp_rom(int a);   // R6
        return ((a * 29 + 7) ^ (a >> 4)) & 255;
    endfunction

    function automatic bit want_bad(int n);
        if (n < 16) return 1'b0;
        if (n == 31 || n == 32 || n == DEPTH - 1) return 1'b1;
        if (n < 48) return 1'b0;
        return ($urandom % 6) == 0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // Present the byte for pulse n (address n mod DEPTH), maybe corrupted. R5
    task automatic present(int n);
        bit bad;
        int mask;
        bad  = want_bad(n);
        mask = bad ? (($urandom % 255) + 1) : 0;
        data = 8'(exp_rom(n % DEPTH) ^ mask);
        grp_err = grp_err | bad;
    endtask

    task automatic hold_reset(bit a, bit b, bit c);
        @(negedge clk);
        rst = 1'b1; s_strobe = a; s_fetch = b; s_ext = c;
        repeat (3) begin
            @(negedge clk);
            chk(strobe_o == 1'b0, "R2 strobe in reset", strobe_o, 0);
            chk(verdict_o == 1'b1, "R2 verdict in reset", verdict_o, 1);
        end
    endtask

    // Active run: per-cycle model of strobe timing and verdict. R3 R4 R5 R7 R8 R9
    task automatic run_active(int ncyc, string ptag);
        grp_err = 1'b0;
        exp_v   = 1'b1;
        present(0);
        rst = 1'b0;
        for (int cyc = 0; cyc < ncyc; cyc++) begin
            bit exp_s;
            bit close;
            int k;
            @(negedge clk);
            close = 1'b0;
            k = -1;
            if (cyc >= 7 && (cyc - 7) % 3 == 0) begin
                k = (cyc - 7) / 3;
                if (k % 16 == 15) begin
                    exp_v   = !grp_err;
                    grp_err = 1'b0;
                    close   = 1'b1;
                end
                present(k + 1);
            end
            exp_s = (cyc >= 6) && ((cyc - 6) % 3 == 0);
            chk(strobe_o == exp_s, (cyc <= 6) ? {ptag, " R3 first strobe"} : {ptag, " R4 strobe period"},
                strobe_o, exp_s);
            if (close)
                chk(verdict_o == exp_v,
                    (k >= DEPTH) ? {ptag, " R7 R8 verdict after wrap"} : {ptag, " R8 R5 R6 group verdict"},
                    verdict_o, exp_v);
            else
                chk(verdict_o == exp_v, {ptag, " R9 verdict hold"}, verdict_o, exp_v);
        end
    endtask

    // Wrong straps: block must stay quiet. R1
    task automatic run_idle(bit a, bit b, bit c);
        hold_reset(a, b, c);
        rst = 1'b0;
        for (int cyc = 0; cyc < 60; cyc++) begin
            @(negedge clk);
            data = 8'($urandom);
            chk(strobe_o == 1'b0, "R1 idle strobe", strobe_o, 0);
            chk(verdict_o == 1'b1, "R1 idle verdict", verdict_o, 1);
        end
    endtask

    initial begin
        seed = $urandom(32'h1234);
        hold_reset(1'b0, 1'b1, 1'b1);
        run_active(2 * DEPTH * 3 + 60, "main");
        hold_reset(1'b0, 1'b1, 1'b1);
        run_active(100, "cut");
        hold_reset(1'b0, 1'b1, 1'b1);          // R10: restart mid group
        run_active(200, "R10 restart");
        run_idle(1'b1, 1'b1, 1'b1);
        run_idle(1'b0, 1'b0, 1'b1);
        run_idle(1'b0, 1'b1, 1'b0);
        hold_reset(1'b0, 1'b1, 1'b1);
        run_active(150, "R10 after idle");
        finish_run();
    end

    initial begin
        #(200000 * 8);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule